// File: doc/BRIEF.md
# Vector Integer Reduction Unit

This block folds the elements of a vector register group into a single scalar. A request carries the operation, the element width, the register-group size, the active length, the start index, the vector status bits, the index of the source group, the masking control and the mask bits. When a request arrives the block latches all of it. In the next cycle it decides whether the instruction is legal. A legal request then reads the source elements one per cycle through a combinational register-file read port, starting at index 0. Each active element is merged into an accumulator that was seeded from element 0 of the scalar source register.

When the operation ends, the block raises `done` for one cycle. In that cycle it presents either the scalar result, with a write strobe for element 0 of the destination, or an illegal-instruction flag with no write. The rest of the destination register is not touched. Decode, register storage and trap delivery lie outside the block.

Top module: `vec_red_unit`

## Requirements
- R1: If `vec_en` is 0, the request ends with `illegal`=1 and `wr_en`=0. `done` and `illegal` appear exactly two cycles after the start cycle.
- R2: If `vill` is 1, the request is illegal and writes nothing.
- R3: Any nonzero `vstart` makes the request illegal, and no element is read.
- R4: `lmul` selects the group size: 0→1, 1→2, 2→4, 3→8 registers. If `vs2_idx` is not a multiple of the group size, the request is illegal. An aligned index, such as 8 with `lmul`=3, is legal.
- R5: The widening operations (codes 8 and 9) with `sew`=3 (64-bit) are illegal. Operation codes 10 to 15 are illegal.
- R6: The element width is set by `sew`: 0→8, 1→16, 2→32, 3→64 bits. The non-widening operations use these codes: 0 wrapping sum, 1 AND, 2 OR, 3 XOR. They start from `seed` truncated to SEW bits. The result holds SEW bits and is zero above them.
- R7: Unsigned min (code 4) and unsigned max (code 6) compare both operands truncated to SEW bits.
- R8: Signed min (code 5) and signed max (code 7) compare both operands sign-extended from bit SEW-1.
- R9: Widening unsigned sum (code 8) zero-extends each element to 2×SEW. Widening signed sum (code 9) sign-extends each element. The seed and the result are 2×SEW bits wide, and the sum wraps at that width.
- R10: With `vm`=0, element i takes part only when `mask[i]`=1. With `vm`=1, every element below `vl` takes part.
- R11: With `vl`=0, a legal request completes two cycles after the start cycle, with `wr_en`=0 and no element read.
- R12: A legal request with `vl`=N reads indices 0 to N-1 in order, one per cycle, and then pulses `done` with `wr_en`=1 at cycle N+2 after the start cycle. `done` never lasts longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted while not busy |
| op | input | 4 | Operation code |
| sew | input | 2 | Element width code |
| lmul | input | 2 | Register group size code |
| vl | input | VW | Active length |
| vstart | input | VW | Start index |
| vec_en | input | 1 | Vector instructions currently allowed |
| vill | input | 1 | Current vector type is invalid |
| vs2_idx | input | 5 | Source group register index |
| vm | input | 1 | 1 = unmasked, 0 = use mask bits |
| mask | input | MAXE | Mask bits, one per element |
| seed | input | ELEN | Element 0 of the scalar source register |
| elem_rd | output | 1 | Element read request |
| elem_idx | output | IW | Element index being read |
| elem_data | input | ELEN | Element value returned in the same cycle |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Illegal-instruction flag, valid with done |
| wr_en | output | 1 | Write element 0 of the destination, valid with done |
| result | output | ELEN | Scalar result, valid with done |

## Verification
The bench builds the block with ELEN=64 and MAXE=64. This makes every SEW code reachable, including the 64-bit case that is illegal for the widening operations. It also lets `vl` reach 64, which takes the 6-bit element counter to its last value. Each scenario uses element values whose top bits are set. This separates signed from unsigned comparison, zero-extension from sign-extension, and wrapping at the narrow width from wrapping at the wide one.

// File: rtl/vec_red_unit.sv
module vec_red_unit #(
  parameter int ELEN = 64,
  parameter int MAXE = 64,
  localparam int IW = $clog2(MAXE),
  localparam int VW = $clog2(MAXE + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      op,
  input  logic [1:0]      sew,
  input  logic [1:0]      lmul,
  input  logic [VW-1:0]   vl,
  input  logic [VW-1:0]   vstart,
  input  logic            vec_en,
  input  logic            vill,
  input  logic [4:0]      vs2_idx,
  input  logic            vm,
  input  logic [MAXE-1:0] mask,
  input  logic [ELEN-1:0] seed,
  output logic            elem_rd,
  output logic [IW-1:0]   elem_idx,
  input  logic [ELEN-1:0] elem_data,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic            wr_en,
  output logic [ELEN-1:0] result
);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_RUN, S_DONE} st_t;

  st_t             st;
  logic [3:0]      op_q;
  logic [1:0]      sew_q, lmul_q;
  logic [VW-1:0]   vl_q, vst_q;
  logic            ven_q, vill_q, vm_q, ill_q, wr_q;
  logic [4:0]      vs2_q;
  logic [MAXE-1:0] mask_q;
  logic [ELEN-1:0] seed_q, acc, nxt;
  logic [IW-1:0]   idx;

  function automatic logic [ELEN-1:0] lowmask(input int bits);
    if (bits >= ELEN) return '1;
    return (ELEN'(1) << bits) - ELEN'(1);
  endfunction

  function automatic logic [ELEN-1:0] sext(input logic [ELEN-1:0] x, input int bits);
    logic [ELEN-1:0] m;
    m = lowmask(bits);
    return x[bits-1] ? (x | ~m) : (x & m);
  endfunction

  int              sb;
  logic            widen, bad, active, last;
  logic [ELEN-1:0] m1, m2, ea, aa, es, as_;

  assign sb     = 32'd8 << sew_q;
  assign widen  = (op_q == 4'd8) || (op_q == 4'd9);
  assign m1     = lowmask(sb);
  assign m2     = lowmask(2 * sb);
  assign ea     = elem_data & m1;
  assign aa     = acc & m1;
  assign es     = sext(elem_data, sb);
  assign as_    = sext(acc, sb);
  assign active = vm_q || mask_q[idx];
  assign last   = ({1'b0, idx} == IW'(vl_q - VW'(1)));

  assign bad = !ven_q || vill_q || (vst_q != '0)
             || ((vs2_q & ((5'd1 << lmul_q) - 5'd1)) != 5'd0)
             || (op_q > 4'd9)
             || (widen && (2 * sb > ELEN));

  always_comb begin
    unique case (op_q)
      4'd0: nxt = (acc + elem_data) & m1;
      4'd1: nxt = aa & ea;
      4'd2: nxt = aa | ea;
      4'd3: nxt = aa ^ ea;
      4'd4: nxt = (ea < aa) ? ea : aa;
      4'd5: nxt = ($signed(es) < $signed(as_)) ? ea : aa;
      4'd6: nxt = (ea > aa) ? ea : aa;
      4'd7: nxt = ($signed(es) > $signed(as_)) ? ea : aa;
      4'd8: nxt = (acc + ea) & m2;
      4'd9: nxt = (acc + es) & m2;
      default: nxt = acc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_q <= '0; sew_q <= '0; lmul_q <= '0; vl_q <= '0; vst_q <= '0;
      ven_q <= 1'b0; vill_q <= 1'b0; vm_q <= 1'b1; vs2_q <= '0;
      mask_q <= '0; seed_q <= '0; acc <= '0; idx <= '0;
      ill_q <= 1'b0; wr_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          op_q <= op; sew_q <= sew; lmul_q <= lmul; vl_q <= vl; vst_q <= vstart;
          ven_q <= vec_en; vill_q <= vill; vm_q <= vm; vs2_q <= vs2_idx;
          mask_q <= mask; seed_q <= seed;
          st <= S_CHECK;
        end
        S_CHECK: begin
          idx <= '0;
          acc <= seed_q & (widen ? m2 : m1);
          ill_q <= bad;
          wr_q <= !bad && (vl_q != '0);
          st <= (bad || vl_q == '0) ? S_DONE : S_RUN;
        end
        S_RUN: begin
          if (active) acc <= nxt;
          idx <= idx + IW'(1);
          if (last) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign illegal  = done && ill_q;
  assign wr_en    = done && wr_q;
  assign result   = acc;
  assign elem_rd  = (st == S_RUN);
  assign elem_idx = idx;

endmodule

module vec_red_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic vec_en,
  input logic busy,
  input logic done,
  input logic illegal,
  input logic wr_en,
  input logic elem_rd
);

  p_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !vec_en) |=> ##1 (done && illegal && !wr_en));

  p_flag_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  p_no_write_when_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (done && !illegal));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && !elem_rd));

  p_read_in_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
    elem_rd |-> (busy && !done));

endmodule

bind vec_red_unit vec_red_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .vec_en(vec_en), .busy(busy),
  .done(done), .illegal(illegal), .wr_en(wr_en), .elem_rd(elem_rd)
);

// File: tb/tb_vec_red_unit.sv
module tb_vec_red_unit;
  localparam int ELEN = 64;
  localparam int MAXE = 64;
  localparam int IW = $clog2(MAXE);
  localparam int VW = $clog2(MAXE + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] op = '0;
  logic [1:0] sew = '0, lmul = '0;
  logic [VW-1:0] vl = '0, vstart = '0;
  logic vec_en = 1'b1, vill = 1'b0, vm = 1'b1;
  logic [4:0] vs2_idx = '0;
  logic [MAXE-1:0] mask = '0;
  logic [ELEN-1:0] seed = '0;
  logic elem_rd, busy, done, illegal, wr_en;
  logic [IW-1:0] elem_idx;
  logic [ELEN-1:0] elem_data, result;
  logic [63:0] mem [MAXE];

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  assign elem_data = mem[elem_idx];

  vec_red_unit #(.ELEN(ELEN), .MAXE(MAXE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sew(sew), .lmul(lmul),
    .vl(vl), .vstart(vstart), .vec_en(vec_en), .vill(vill), .vs2_idx(vs2_idx),
    .vm(vm), .mask(mask), .seed(seed), .elem_rd(elem_rd), .elem_idx(elem_idx),
    .elem_data(elem_data), .busy(busy), .done(done), .illegal(illegal),
    .wr_en(wr_en), .result(result)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] msk(input int b);
    return (b >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << b) - 64'd1);
  endfunction

  function automatic longint sgn(input logic [63:0] x, input int b);
    return longint'(x << (64 - b)) >>> (64 - b);
  endfunction

  function automatic logic [63:0] model(input int o, input int b, input logic m_vm,
                                        input logic [MAXE-1:0] m, input int n,
                                        input logic [63:0] s);
    logic [63:0] a, e;
    int w;
    w = (o >= 8) ? 2 * b : b;
    a = s & msk(w);
    for (int i = 0; i < n; i++) begin
      if (m_vm || m[i]) begin
        e = mem[i] & msk(b);
        case (o)
          0: a = (a + e) & msk(b);
          1: a = a & e;
          2: a = a | e;
          3: a = a ^ e;
          4: if (e < a) a = e;
          5: if (sgn(e, b) < sgn(a, b)) a = e;
          6: if (e > a) a = e;
          7: if (sgn(e, b) > sgn(a, b)) a = e;
          8: a = (a + e) & msk(w);
          default: a = (a + 64'(sgn(e, b))) & msk(w);
        endcase
      end
    end
    return a;
  endfunction

  task automatic run(input string req, input int o, input int sc, input int lm, input int n,
                     input int vst, input logic ven, input logic vl_bad, input int v2,
                     input logic m_vm, input logic [MAXE-1:0] m, input logic [63:0] s,
                     input logic exp_ill);
    int cyc, reads, b;
    logic [63:0] exp;
    b = 8 << sc;
    @(negedge clk);
    op = 4'(o); sew = 2'(sc); lmul = 2'(lm); vl = VW'(n); vstart = VW'(vst);
    vec_en = ven; vill = vl_bad; vs2_idx = 5'(v2); vm = m_vm; mask = m; seed = s;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; reads = 0;
    while (!done && cyc < 500) begin
      if (elem_rd) begin
        check({req, " read order"}, 64'(elem_idx), 64'(reads));
        reads++;
      end
      @(negedge clk);
      cyc++;
    end
    check({req, " illegal"}, 64'(illegal), 64'(exp_ill));
    if (exp_ill || n == 0) begin
      check({req, " no write"}, 64'(wr_en), 64'd0);
      check({req, " latency"}, 64'(cyc), 64'd2);
      check({req, " no reads"}, 64'(reads), 64'd0);
    end else begin
      exp = model(o, b, m_vm, m, n, s);
      check({req, " write"}, 64'(wr_en), 64'd1);
      check({req, " result"}, result, exp);
      check({req, " latency"}, 64'(cyc), 64'(n + 2));
      check({req, " reads"}, 64'(reads), 64'(n));
    end
    @(negedge clk);
    check({req, " done one cycle"}, 64'(done), 64'd0);
  endtask

  task automatic fill(input logic [63:0] base, input logic [63:0] step);
    for (int i = 0; i < MAXE; i++) mem[i] = base + step * 64'(i) ^ (64'(i) << 61);
  endtask

  task automatic t_reset;
    check("R12 reset busy", 64'(busy), 64'd0);
    check("R12 reset done", 64'(done), 64'd0);
    check("R12 reset rd", 64'(elem_rd), 64'd0);
  endtask

  task automatic t_illegal;
    fill(64'h1111, 64'h0F0F);
    run("R1 disabled", 0, 0, 0, 4, 0, 1'b0, 1'b0, 0, 1'b1, '0, 64'h5, 1'b1);
    run("R2 vill", 0, 0, 0, 4, 0, 1'b1, 1'b1, 0, 1'b1, '0, 64'h5, 1'b1);
    run("R3 vstart", 0, 0, 0, 4, 3, 1'b1, 1'b0, 0, 1'b1, '0, 64'h5, 1'b1);
    run("R4 misaligned lmul2", 1, 1, 1, 4, 0, 1'b1, 1'b0, 3, 1'b1, '0, 64'h5, 1'b1);
    run("R4 misaligned lmul8", 1, 1, 3, 4, 0, 1'b1, 1'b0, 12, 1'b1, '0, 64'h5, 1'b1);
    run("R4 aligned lmul8", 0, 1, 3, 5, 0, 1'b1, 1'b0, 8, 1'b1, '0, 64'h5, 1'b0);
    run("R5 widen sew64", 8, 3, 0, 4, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'h5, 1'b1);
    run("R5 bad opcode", 12, 0, 0, 4, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'h5, 1'b1);
  endtask

  task automatic t_logic;
    fill(64'hF0F0_1234_89AB_CDEF, 64'h0101_0101_0101_0131);
    run("R6 sum sew8 wrap", 0, 0, 0, 9, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0);
    run("R6 sum sew64", 0, 3, 0, 7, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'hFFFF_0000_0000_0001, 1'b0);
    run("R6 and sew16", 1, 1, 0, 6, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'hABCD_FFFF, 1'b0);
    run("R6 or sew32", 2, 2, 0, 6, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'h1_0000_0001, 1'b0);
    run("R6 xor sew16", 3, 1, 0, 10, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'h55AA, 1'b0);
  endtask

  task automatic t_minmax;
    fill(64'h0000_0000_0000_0070, 64'h0000_0000_0000_0009);
    run("R7 minu sew8", 4, 0, 0, 16, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'hFF, 1'b0);
    run("R7 maxu sew8", 6, 0, 0, 16, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'h01, 1'b0);
    run("R8 min sew8", 5, 0, 0, 16, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'h10, 1'b0);
    run("R8 max sew8", 7, 0, 0, 16, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'hF0, 1'b0);
    fill(64'h7FFF_FFF0, 64'h0000_0000_1000_0003);
    run("R8 min sew32", 5, 2, 0, 12, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'h0, 1'b0);
    run("R7 maxu sew32", 6, 2, 0, 12, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'h0, 1'b0);
    run("R8 max sew64", 7, 3, 0, 12, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'h8000_0000_0000_0000, 1'b0);
  endtask

  task automatic t_widen;
    for (int i = 0; i < MAXE; i++) mem[i] = 64'hFFFF_FFFF_FFFF_FFF0 | 64'(i);
    run("R9 wsumu sew8", 8, 0, 0, 5, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'h1_FF00, 1'b0);
    run("R9 wsum sew8", 9, 0, 0, 5, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'h1_0010, 1'b0);
    run("R9 wsumu sew32", 8, 2, 0, 3, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'hFFFF_FFFF_0000_0000, 1'b0);
    run("R9 wsum sew32", 9, 2, 0, 3, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'h40, 1'b0);
  endtask

  task automatic t_mask;
    fill(64'h3, 64'h11);
    run("R10 masked sum", 0, 1, 0, 20, 0, 1'b1, 1'b0, 0, 1'b0, 64'h0000_0000_000A_5C31, 64'h7, 1'b0);
    run("R10 masked minu", 4, 1, 0, 20, 0, 1'b1, 1'b0, 0, 1'b0, 64'h0000_0000_0008_0000, 64'hFFFF, 1'b0);
    run("R10 all masked", 2, 0, 0, 8, 0, 1'b1, 1'b0, 0, 1'b0, 64'h0, 64'h42, 1'b0);
  endtask

  task automatic t_edges;
    fill(64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111);
    run("R11 vl zero", 0, 0, 0, 0, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'h9, 1'b0);
    run("R12 vl max", 0, 3, 0, MAXE, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'h1, 1'b0);
    run("R12 vl one", 3, 2, 0, 1, 0, 1'b1, 1'b0, 0, 1'b1, '0, 64'hDEAD_BEEF, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < MAXE; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_illegal;
    t_logic;
    t_minmax;
    t_widen;
    t_mask;
    t_edges;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule